// File: doc/BRIEF.md
# Sleep-Mode Wake Request Filter

This block watches two already-synchronized inputs while a transceiver is asleep and decides when either one represents a genuine request to wake up. The first input is the bus line level, where 1 is recessive and 0 is dominant. A remote request is a dominant pulse that starts with a falling edge, stays dominant for a qualifying time, and ends with a return to recessive. The second input is a local wake pin, where 1 is high and 0 is low. A local request is a falling edge followed by a low that lasts long enough. Only one such request is accepted per falling edge. Before a new falling edge can arm the pin filter, the pin must first be high for a minimum time.

All qualifying times are counted in clock cycles and are set by parameters. Outside sleep, both filters are held in their initial state and stay silent. Each detected request produces a one-cycle pulse on its own output. A supervising mode controller uses these pulses to leave sleep. Two protections stop a level that was already present at sleep entry from waking the device by itself: a bus that is already dominant, or a pin that is already low.

Top module: `wake_filter_top`

## Requirements
- R1: While reset is high, and in the first cycle after reset, both `remote_wake_o` and `local_wake_o` are 0.
- R2: In sleep (`sleep_i`=1), a run of at least BUS_HOLD_CYC consecutive dominant samples (`bus_lvl_i`=0) must follow a recessive sample. When it is then followed by a recessive sample (`bus_lvl_i`=1), `remote_wake_o` is 1 for exactly the cycle after the clock edge that samples that recessive level.
- R3: A dominant run shorter than BUS_HOLD_CYC samples, followed by a recessive sample, gives no remote pulse. The next falling edge starts a new count from zero.
- R4: A bus that is dominant when sleep is entered does not count toward a remote wake. The bus must first be sampled recessive, and only a later falling edge can start a qualifying run.
- R5: In sleep, once the pin filter is armed, a run of PIN_LOW_CYC consecutive low samples (`pin_lvl_i`=0) makes `local_wake_o` 1 for exactly the cycle after the edge that samples the last low of that run. No rising edge is needed.
- R6: A pin low run shorter than PIN_LOW_CYC samples gives no local pulse.
- R7: The pin filter is armed only after PIN_REARM_CYC consecutive high samples taken in sleep. The count restarts on every sleep entry, after every local wake, and after every low run that is too short. A low that follows fewer high samples gives no local pulse, however long it lasts. A pin held low gives no further pulses.
- R8: While `sleep_i`=0, both outputs stay 0 whatever the input levels, and both filters return to their sleep-entry state.
- R9: Each output pulse lasts one cycle. When both filters qualify on the same sampled cycle, both outputs are 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | 1 while the device is in sleep mode |
| bus_lvl_i | input | 1 | Synchronized bus level, 1 recessive, 0 dominant |
| pin_lvl_i | input | 1 | Synchronized wake pin level, 1 high, 0 low |
| remote_wake_o | output | 1 | One-cycle pulse for a qualified bus wake request |
| local_wake_o | output | 1 | One-cycle pulse for a qualified pin wake request |

## Verification
The assertions assume that the input levels are already synchronized to `clk`. They also assume that each filter length is at least two cycles, so a pulse always has at least two sampled cycles of history behind it. The bench drives all three inputs once per cycle, on the falling clock edge, with the filter lengths set to a few cycles. This means every dominant run, low run and high run it applies is an exact, known number of samples. The sweeps step through run lengths on both sides of each threshold. The expected pulse is derived only from comparing the applied run length with the threshold.

// File: rtl/wkf_pkg.sv
package wkf_pkg;

  typedef enum logic [1:0] {
    BUS_NEED_REC = 2'd0,
    BUS_ARMED    = 2'd1,
    BUS_DOM      = 2'd2,
    BUS_HELD     = 2'd3
  } bus_st_e;

  typedef enum logic [1:0] {
    PIN_REARM = 2'd0,
    PIN_ARMED = 2'd1,
    PIN_LOW   = 2'd2
  } pin_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bus_wake_filter.sv
module bus_wake_filter #(
  parameter int HOLD_CYC = 18000
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  input  logic lvl_i,
  output logic wake_o
);
  import wkf_pkg::*;

  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  bus_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          wake_q;

  always_ff @(posedge clk) begin
    if (rst || !sleep_i) begin
      st_q   <= BUS_NEED_REC;
      cnt_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      case (st_q)
        BUS_NEED_REC: begin
          if (lvl_i) st_q <= BUS_ARMED;
        end
        BUS_ARMED: begin
          if (!lvl_i) begin
            st_q  <= BUS_DOM;
            cnt_q <= CW'(1);
          end
        end
        BUS_DOM: begin
          if (lvl_i) begin
            st_q <= BUS_ARMED;
          end else if (cnt_q == LAST) begin
            st_q <= BUS_HELD;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        BUS_HELD: begin
          if (lvl_i) begin
            wake_q <= 1'b1;
            st_q   <= BUS_ARMED;
          end
        end
        default: st_q <= BUS_NEED_REC;
      endcase
    end
  end

  assign wake_o = wake_q;

endmodule

// File: rtl/pin_wake_filter.sv
module pin_wake_filter #(
  parameter int LOW_CYC   = 7000,
  parameter int REARM_CYC = 1201
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  input  logic lvl_i,
  output logic wake_o
);
  import wkf_pkg::*;

  localparam int CW = $clog2(max2(LOW_CYC, REARM_CYC) + 1);
  localparam logic [CW-1:0] LOW_LAST = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HI_LAST  = CW'(REARM_CYC - 1);

  pin_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          wake_q;

  always_ff @(posedge clk) begin
    if (rst || !sleep_i) begin
      st_q   <= PIN_REARM;
      cnt_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      case (st_q)
        PIN_REARM: begin
          if (!lvl_i) begin
            cnt_q <= '0;
          end else if (cnt_q == HI_LAST) begin
            st_q  <= PIN_ARMED;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        PIN_ARMED: begin
          if (!lvl_i) begin
            st_q  <= PIN_LOW;
            cnt_q <= CW'(1);
          end
        end
        PIN_LOW: begin
          if (lvl_i) begin
            st_q  <= PIN_REARM;
            cnt_q <= CW'(1);
          end else if (cnt_q == LOW_LAST) begin
            wake_q <= 1'b1;
            st_q   <= PIN_REARM;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: st_q <= PIN_REARM;
      endcase
    end
  end

  assign wake_o = wake_q;

endmodule

// File: rtl/wake_filter_top.sv
module wake_filter_top #(
  parameter int BUS_HOLD_CYC  = 18000,
  parameter int PIN_LOW_CYC   = 7000,
  parameter int PIN_REARM_CYC = 1201
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  input  logic bus_lvl_i,
  input  logic pin_lvl_i,
  output logic remote_wake_o,
  output logic local_wake_o
);

  bus_wake_filter #(
    .HOLD_CYC(BUS_HOLD_CYC)
  ) u_bus (
    .clk    (clk),
    .rst    (rst),
    .sleep_i(sleep_i),
    .lvl_i  (bus_lvl_i),
    .wake_o (remote_wake_o)
  );

  pin_wake_filter #(
    .LOW_CYC  (PIN_LOW_CYC),
    .REARM_CYC(PIN_REARM_CYC)
  ) u_pin (
    .clk    (clk),
    .rst    (rst),
    .sleep_i(sleep_i),
    .lvl_i  (pin_lvl_i),
    .wake_o (local_wake_o)
  );

endmodule

// File: rtl/wake_filter_chk.sv
module wake_filter_chk (
  input logic clk,
  input logic rst,
  input logic sleep_i,
  input logic bus_lvl_i,
  input logic pin_lvl_i,
  input logic remote_wake_o,
  input logic local_wake_o
);

  // R1: outputs quiet in the cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!remote_wake_o && !local_wake_o));

  // R8: no pulse unless sleep was sampled
  assert_remote_only_in_sleep_R8: assert property (@(posedge clk) disable iff (rst)
    remote_wake_o |-> $past(sleep_i));

  assert_local_only_in_sleep_R8: assert property (@(posedge clk) disable iff (rst)
    local_wake_o |-> $past(sleep_i));

  // R2: remote pulse follows a dominant sample then a recessive sample
  assert_remote_edge_R2: assert property (@(posedge clk) disable iff (rst)
    remote_wake_o |-> ($past(bus_lvl_i) && !$past(bus_lvl_i, 2)));

  // R5: local pulse follows at least two low samples
  assert_local_low_R5: assert property (@(posedge clk) disable iff (rst)
    local_wake_o |-> (!$past(pin_lvl_i) && !$past(pin_lvl_i, 2)));

  // R9: single-cycle pulses
  assert_remote_single_R9: assert property (@(posedge clk) disable iff (rst)
    remote_wake_o |=> !remote_wake_o);

  assert_local_single_R9: assert property (@(posedge clk) disable iff (rst)
    local_wake_o |=> !local_wake_o);

endmodule

bind wake_filter_top wake_filter_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .sleep_i      (sleep_i),
  .bus_lvl_i    (bus_lvl_i),
  .pin_lvl_i    (pin_lvl_i),
  .remote_wake_o(remote_wake_o),
  .local_wake_o (local_wake_o)
);

// File: tb/tb_wake_filter_top.sv
`timescale 1ns/1ps
module tb_wake_filter_top;
  localparam int NB = 5;
  localparam int NP = 4;
  localparam int NR = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_i = 1'b0;
  logic bus_lvl_i = 1'b1;
  logic pin_lvl_i = 1'b1;
  logic remote_wake_o, local_wake_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  wake_filter_top #(
    .BUS_HOLD_CYC (NB),
    .PIN_LOW_CYC  (NP),
    .PIN_REARM_CYC(NR)
  ) dut (
    .clk          (clk),
    .rst          (rst),
    .sleep_i      (sleep_i),
    .bus_lvl_i    (bus_lvl_i),
    .pin_lvl_i    (pin_lvl_i),
    .remote_wake_o(remote_wake_o),
    .local_wake_o (local_wake_o)
  );

  task automatic check(input string tag, input logic er, input logic el);
    n_chk++;
    if (remote_wake_o !== er || local_wake_o !== el) begin
      n_fail++;
      $display("FAIL %s t=%0t remote=%0b exp=%0b local=%0b exp=%0b",
               tag, $time, remote_wake_o, er, local_wake_o, el);
    end
  endtask

  // drive one sample on the falling edge, check after the next rising edge
  task automatic step(input logic b, input logic p, input logic s,
                      input logic er, input logic el, input string tag);
    @(negedge clk);
    bus_lvl_i = b;
    pin_lvl_i = p;
    sleep_i   = s;
    @(posedge clk);
    #1;
    check(tag, er, el);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 after reset", 1'b0, 1'b0);

    // R2/R3: sweep dominant run length across the threshold
    step(1, 1, 1, 0, 0, "R2 sleep entry");
    for (int len = 1; len <= NB + 2; len++) begin
      for (int k = 0; k < len; k++) step(0, 1, 1, 0, 0, "R3 dominant run");
      step(1, 1, 1, (len >= NB), 0, (len >= NB) ? "R2 qualified pulse" : "R3 short run");
      step(1, 1, 1, 0, 0, "R9 pulse ends");
    end

    // R4: dominant at sleep entry is ignored
    step(0, 1, 0, 0, 0, "R8 awake dominant");
    for (int k = 0; k < NB + 3; k++) step(0, 1, 1, 0, 0, "R4 dominant at entry");
    step(1, 1, 1, 0, 0, "R4 no wake on release");
    for (int k = 0; k < NB; k++) step(0, 1, 1, 0, 0, "R4 fresh run");
    step(1, 1, 1, 1, 0, "R4 fresh fall wakes");

    // R8: nothing outside sleep
    for (int k = 0; k < NB + 2; k++) step(0, 0, 0, 0, 0, "R8 awake lows");
    step(1, 1, 0, 0, 0, "R8 awake release");

    // R7/R5: sweep high time before the falling edge
    for (int h = 1; h <= NR + 1; h++) begin
      step(1, 1, 0, 0, 0, "R8 leave sleep");
      for (int k = 0; k < h; k++) step(1, 1, 1, 0, 0, "R7 high run");
      for (int k = 1; k <= NP; k++)
        step(1, 0, 1, 0, (k == NP) && (h >= NR),
             (h >= NR) ? "R5 local pulse" : "R7 not armed");
      for (int k = 0; k < 3; k++) step(1, 0, 1, 0, 0, "R7 held low no repeat");
    end

    // R7: pin low at sleep entry never wakes
    step(1, 0, 0, 0, 0, "R8 leave sleep");
    for (int k = 0; k < NP + NR + 4; k++) step(1, 0, 1, 0, 0, "R7 low at entry");

    // R6: short low, then rearm is required again
    for (int k = 0; k < NR; k++) step(1, 1, 1, 0, 0, "R7 rearm");
    for (int k = 0; k < NP - 1; k++) step(1, 0, 1, 0, 0, "R6 short low");
    step(1, 1, 1, 0, 0, "R6 release");
    for (int k = 0; k < NP + 1; k++) step(1, 0, 1, 0, 0, "R6 low after short high");
    for (int k = 0; k < NR - 1; k++) step(1, 1, 1, 0, 0, "R7 too short high");
    for (int k = 0; k < NP; k++) step(1, 0, 1, 0, 0, "R7 after short high");
    for (int k = 0; k < NR; k++) step(1, 1, 1, 0, 0, "R7 full high");
    for (int k = 1; k <= NP; k++) step(1, 0, 1, 0, (k == NP), "R5 after rearm");

    // R9: both sources qualify on the same sample
    step(1, 1, 0, 0, 0, "R8 leave sleep");
    for (int k = 0; k < NR + 1; k++) step(1, 1, 1, 0, 0, "R9 prep");
    for (int k = 0; k < NB; k++)
      step(0, (k >= NB - NP + 1) ? 1'b0 : 1'b1, 1, 0, 0, "R9 overlap");
    step(1, 0, 1, 1, 1, "R9 simultaneous pulses");
    step(1, 0, 1, 0, 0, "R9 both end");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule